// File: doc/BRIEF.md
# Bit-Serial Compare-Exchange Sorting Element

This element is one node of a bit-serial sorting network. Two cells arrive on two single-bit lines, in lockstep. A shared start pulse marks the first bit of both cells. Each cell is sent most significant bit first, in this order:

- a header of one busy flag and an `ADDR_W`-bit routing address;
- a `PAY_W`-bit payload.

The busy flag followed by the address forms the sort key.

The element compares the two headers as the bits stream past. The first header position where the two lines disagree decides which cell has the larger key. From that bit onward, the larger-key cell leaves on the high output and the other cell leaves on the low output. Bits before the first difference are common to both cells, so they appear on both outputs unchanged. Each output lags its input by exactly one clock. The start pulse is forwarded with the same one-clock lag.

Cells never stall, so the data lines carry no valid/ready handshake. A cell is in flight on every clock, and flow control is the job of the acknowledgement path. That path runs against the data. An acknowledgement bit received for the high or low output is returned, one clock later, on the input line that fed that output. The route follows the swap decision that the element has latched.

Top module: `sort_cmpx_elem`

## Requirements
- R1: While reset is active, and in the first clock after reset, the outputs `hi_o`, `lo_o`, `sop_o`, `ack_a_o` and `ack_b_o` are all 0.
- R2: Every data output bit appears exactly one clock after the input bit it comes from. Until the headers differ, `hi_o` and `lo_o` both carry the shared header bits.
- R3: The sort key is the header bits {busy, address}, compared MSB first. The cell with the larger key leaves on `hi_o` and the other cell leaves on `lo_o`. This covers every bit of the cell, including the whole payload.
- R4: When the two keys are equal, cell A leaves on `hi_o` and cell B leaves on `lo_o`. Differences in the payload never cause a swap.
- R5: A cell whose busy flag (first header bit) is 0 is idle. An idle cell always leaves on `lo_o` when the other cell is busy, whatever its address.
- R6: Once a header difference is seen, the swap decision holds until the next start pulse. Each start pulse opens a fresh comparison.
- R7: `ack_a_o` and `ack_b_o` give, one clock later, the value of `ack_hi_i` or `ack_lo_i` for the output that input currently feeds. For example, with a swap latched, `ack_a_o` follows `ack_lo_i`.
- R8: `sop_o` equals `sop_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Start pulse, high during the busy-flag bit of both input cells |
| a_i | input | 1 | Serial cell on input A |
| b_i | input | 1 | Serial cell on input B |
| ack_hi_i | input | 1 | Acknowledgement returned for the high output |
| ack_lo_i | input | 1 | Acknowledgement returned for the low output |
| hi_o | output | 1 | Serial cell with the larger key |
| lo_o | output | 1 | Serial cell with the smaller (or equal, from B) key |
| sop_o | output | 1 | Forwarded start pulse |
| ack_a_o | output | 1 | Acknowledgement sent back toward input A |
| ack_b_o | output | 1 | Acknowledgement sent back toward input B |

## Verification
Every result here is due one clock after its cause:

- A cell bit driven in one cycle shows up on `hi_o` or `lo_o` in the next cycle.
- The start pulse shows up on `sop_o` in the next cycle.
- An acknowledgement pulse shows up on the routed `ack_*_o` line in the next cycle.

The bench drives inputs on the falling edge. On each later falling edge, it first captures the outputs for the bit driven one cycle earlier, then drives the next bit. Each cell is rebuilt this way and compared whole against the cell predicted from the two keys.

The acknowledgement pulse is injected in the payload, well after the header has fixed the decision. It is read back on the following falling edge.

// File: rtl/sort_cmpx_pkg.sv
package sort_cmpx_pkg;
  typedef enum logic {
    ST_OPEN   = 1'b0,
    ST_LOCKED = 1'b1
  } decide_e;
endpackage

// File: rtl/se_key_compare.sv
module se_key_compare
  import sort_cmpx_pkg::*;
#(
  parameter int HDR_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop,
  input  logic bit_a,
  input  logic bit_b,
  output logic swap_now,
  output logic swap_held
);
  localparam int CW = $clog2(HDR_W + 1);

  logic [CW-1:0] left_q;
  decide_e       st_q;
  logic          in_hdr;
  logic          open_cmp;
  logic          differ;

  always_comb begin
    in_hdr   = sop || (left_q != '0);
    open_cmp = sop || (st_q == ST_OPEN);
    differ   = in_hdr && open_cmp && (bit_a != bit_b);
    if (differ)   swap_now = bit_b;
    else if (sop) swap_now = 1'b0;
    else          swap_now = swap_held;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q    <= '0;
      st_q      <= ST_OPEN;
      swap_held <= 1'b0;
    end else begin
      swap_held <= swap_now;
      if (sop)                left_q <= CW'(HDR_W - 1);
      else if (left_q != '0)  left_q <= left_q - CW'(1);
      if (sop)                st_q <= differ ? ST_LOCKED : ST_OPEN;
      else if (differ)        st_q <= ST_LOCKED;
    end
  end
endmodule

// File: rtl/se_swap_path.sv
module se_swap_path (
  input  logic clk,
  input  logic rst_n,
  input  logic swap,
  input  logic sop,
  input  logic bit_a,
  input  logic bit_b,
  output logic hi_q,
  output logic lo_q,
  output logic sop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      sop_q <= 1'b0;
    end else begin
      hi_q  <= swap ? bit_b : bit_a;
      lo_q  <= swap ? bit_a : bit_b;
      sop_q <= sop;
    end
  end
endmodule

// File: rtl/se_ack_return.sv
module se_ack_return (
  input  logic clk,
  input  logic rst_n,
  input  logic swap,
  input  logic ack_hi,
  input  logic ack_lo,
  output logic ack_a_q,
  output logic ack_b_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_a_q <= 1'b0;
      ack_b_q <= 1'b0;
    end else begin
      ack_a_q <= swap ? ack_lo : ack_hi;
      ack_b_q <= swap ? ack_hi : ack_lo;
    end
  end
endmodule

// File: rtl/sort_cmpx_elem.sv
module sort_cmpx_elem #(
  parameter int ADDR_W = 4,
  parameter int PAY_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop_i,
  input  logic a_i,
  input  logic b_i,
  input  logic ack_hi_i,
  input  logic ack_lo_i,
  output logic hi_o,
  output logic lo_o,
  output logic sop_o,
  output logic ack_a_o,
  output logic ack_b_o
);
  localparam int HDR_W  = ADDR_W + 1;
  localparam int CELL_W = HDR_W + PAY_W;

  logic swap_now;
  logic swap_held;

  se_key_compare #(.HDR_W(HDR_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop      (sop_i),
    .bit_a    (a_i),
    .bit_b    (b_i),
    .swap_now (swap_now),
    .swap_held(swap_held)
  );

  se_swap_path u_path (
    .clk  (clk),
    .rst_n(rst_n),
    .swap (swap_now),
    .sop  (sop_i),
    .bit_a(a_i),
    .bit_b(b_i),
    .hi_q (hi_o),
    .lo_q (lo_o),
    .sop_q(sop_o)
  );

  se_ack_return u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .swap   (swap_held),
    .ack_hi (ack_hi_i),
    .ack_lo (ack_lo_i),
    .ack_a_q(ack_a_o),
    .ack_b_q(ack_b_o)
  );

  initial begin
    if (CELL_W < 2) $error("cell too short");
  end
endmodule

// File: rtl/sort_cmpx_checker.sv
module sort_cmpx_checker (
  input logic clk,
  input logic rst_n,
  input logic sop_i,
  input logic a_i,
  input logic b_i,
  input logic ack_hi_i,
  input logic ack_lo_i,
  input logic hi_o,
  input logic lo_o,
  input logic sop_o,
  input logic ack_a_o,
  input logic ack_b_o
);
  p_sop_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i |=> sop_o);

  p_sop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sop_i |=> !sop_o);

  p_shared_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == b_i) |=> (hi_o == lo_o) && (hi_o == $past(a_i)));

  p_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i != b_i) |=> (hi_o != lo_o));

  p_ack_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hi_i != ack_lo_i) |=> (ack_a_o != ack_b_o));

  p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_hi_i && !ack_lo_i) |=> (!ack_a_o && !ack_b_o));
endmodule

bind sort_cmpx_elem sort_cmpx_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sop_i   (sop_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .ack_hi_i(ack_hi_i),
  .ack_lo_i(ack_lo_i),
  .hi_o    (hi_o),
  .lo_o    (lo_o),
  .sop_o   (sop_o),
  .ack_a_o (ack_a_o),
  .ack_b_o (ack_b_o)
);

// File: tb/tb_sort_cmpx_elem.sv
module tb_sort_cmpx_elem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop_i = 1'b0, a_i = 1'b0, b_i = 1'b0;
  logic ack_hi_i = 1'b0, ack_lo_i = 1'b0;
  logic hi_o, lo_o, sop_o, ack_a_o, ack_b_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sort_cmpx_elem dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .a_i(a_i), .b_i(b_i),
    .ack_hi_i(ack_hi_i), .ack_lo_i(ack_lo_i), .hi_o(hi_o), .lo_o(lo_o),
    .sop_o(sop_o), .ack_a_o(ack_a_o), .ack_b_o(ack_b_o)
  );

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_pair(input logic [4:0] ka, input logic [4:0] kb);
    logic [7:0]  pa, pb;
    logic [12:0] fa, fb, got_hi, got_lo, exp_hi, exp_lo;
    logic        sop_seen, aa_seen, ab_seen, exp_swap;
    string       tag;
    pa = 8'(ka * 7 + kb * 3 + 1);
    pb = ~pa;
    fa = {ka, pa};
    fb = {kb, pb};
    got_hi = '0; got_lo = '0; sop_seen = 1'b0; aa_seen = 1'b0; ab_seen = 1'b0;
    exp_swap = (ka < kb);
    exp_hi = exp_swap ? fb : fa;
    exp_lo = exp_swap ? fa : fb;
    if (ka == kb)           tag = "R4 R6 equal keys";
    else if (ka[4] != kb[4]) tag = "R5 R6 idle vs busy";
    else                    tag = "R2 R3 R6 key order";
    for (int k = 0; k <= 13; k++) begin
      @(negedge clk);
      if (k > 0) begin
        got_hi[13-k] = hi_o;
        got_lo[13-k] = lo_o;
        if (k == 1) sop_seen = sop_o;
        if (k == 10) begin aa_seen = ack_a_o; ab_seen = ack_b_o; end
      end
      if (k < 13) begin
        sop_i = (k == 0); a_i = fa[12-k]; b_i = fb[12-k];
      end else begin
        sop_i = 1'b0; a_i = 1'b0; b_i = 1'b0;
      end
      ack_hi_i = (k == 9);
      ack_lo_i = 1'b0;
    end
    check({tag, " hi"}, got_hi, exp_hi);
    check({tag, " lo"}, got_lo, exp_lo);
    check("R8 start forwarded", {12'd0, sop_seen}, 13'd1);
    check("R7 ack routing", {11'd0, aa_seen, ab_seen}, {11'd0, !exp_swap, exp_swap});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {8'd0, hi_o, lo_o, sop_o, ack_a_o, ack_b_o}, 13'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {8'd0, hi_o, lo_o, sop_o, ack_a_o, ack_b_o}, 13'd0);
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        run_pair(5'(i), 5'(j));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule